// File: doc/BRIEF.md
# Indirect Register Command Bridge

The bridge sits on a 16-bit host register port and gives the host reach into a bank of 256 hidden 16-bit device registers that the host cannot address directly. The host puts a target index and data words into a small staging window. It selects a transfer direction by writing a mode code into a control register. It then launches the transfer by writing a command word whose top bit starts the operation and whose low nibble gives the transfer size. The bridge moves the data between the staging window and the hidden bank in a single cycle.

The host learns that a transfer has finished by polling a status register. Each status read while a transfer is marked busy advances an internal progress count, and the ready bit reports that count. An error flag is reported next to it. It is raised by a command issued under a forbidden mode code or by a power-down write, and it is cleared by a successful launch or by a power-up write. Host addresses are word indices: only the low 8 bits are decoded, and the register window holds 32 words.

Top module: `ixreg_bridge`

## Requirements
- R1: After reset every host word reads 0 except the power word at offset 0x0A, which reads 1. The status read returns 0, and hidden register 0x7E holds 0x001C while every other hidden register holds 0.
- R2: A write stores its data in the host word given by address bits [4:0], but only when address bits [7:5] are zero; other writes are ignored. A read at any offset other than 0x06 returns the stored word selected by address bits [4:0]. This includes the command word at offset 0x00.
- R3: A write to status offset 0x06 does not store its data. It clears the two low bits of the stored progress count.
- R4: A command write (offset 0x00) while the control word (offset 0x02) equals 0x004F or 0x0041 sets the error flag and starts no transfer. The staging words stay as they were and busy is not set.
- R5: A command write with bit 7 clear, or with bit 7 set while control holds a code other than 0x0042, 0x0043, 0x004F or 0x0041, moves no data and does not set busy.
- R6: Write mode (control 0x0043, command bit 7 set, size S = command bits [3:0]) latches the index from staging word 0x10 bits [7:0]. It writes S-1 words, taken from staging words 0x12 upward, into hidden registers index, index+1, and so on, wrapping modulo 256. Size 0 or 1 writes nothing.
- R7: Read mode (control 0x0042, command bit 7 set, size S) copies the hidden register at the latched index into staging words 0x10 up to 0x10+S-1. All other staging words are left unchanged.
- R8: A started transfer in either mode sets busy and clears the error flag.
- R9: Writing 0 to power offset 0x0A sets the error flag, and writing any non-zero value clears it. The value is stored and reads back.
- R10: A status read returns bit 1 of the progress count in bit 1 and the error flag in bit 0, with the other bits zero. While busy, each status read increments the count until it reaches 3. The read after that clears busy. While not busy, status reads leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| host_addr | input | 8 | Host word offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Combinational read data for host_addr |

## Verification
The hidden bank can only be observed through the bridge itself. Each check of a hidden register therefore takes three steps: a write-mode command of size 1 latches the index without storing data, a read-mode command then copies that register into staging, and a plain read returns it. The wrap past index 0xFF and the exact S-1 word count are proven this way for indices 0xFD, 0xFE, 0xFF, 0x00 and 0x01. The status progress sequence depends on history, so a drain sequence first brings the count and busy to a known state: a clearing write, four status reads and a second clearing write. After that, whether a command set busy can be seen from whether later status reads advance.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned HOST_AW  = 5;
  localparam int unsigned BANK_AW  = 8;
  localparam int unsigned SIZE_W   = 4;

  localparam logic [7:0]  OFF_CMD  = 8'h00;
  localparam logic [7:0]  OFF_CTRL = 8'h02;
  localparam logic [7:0]  OFF_STAT = 8'h06;
  localparam logic [7:0]  OFF_PWR  = 8'h0A;
  localparam int unsigned STG_IDX  = 16;   // index word of the staging window
  localparam int unsigned STG_DATA = 18;   // first data word for write mode

  localparam logic [15:0] MODE_WR    = 16'h0043;
  localparam logic [15:0] MODE_RD    = 16'h0042;
  localparam logic [15:0] MODE_BAD_A = 16'h004F;
  localparam logic [15:0] MODE_BAD_B = 16'h0041;

  localparam logic [7:0]  BANK_RST_IDX = 8'h7E;
  localparam logic [15:0] BANK_RST_VAL = 16'h001C;
endpackage

// File: rtl/ixb_cmd_decode.sv
module ixb_cmd_decode
  import ixb_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SZW = SIZE_W
) (
  input  logic           wr_en,
  input  logic [7:0]     wr_off,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  ctrl,
  output logic           bad_mode,
  output logic           go_wr,
  output logic           go_rd,
  output logic [SZW-1:0] size
);
  logic is_cmd;
  logic forbidden;
  logic launch;

  always_comb begin
    is_cmd    = wr_en && (wr_off == OFF_CMD);
    forbidden = (ctrl == DW'(MODE_BAD_A)) || (ctrl == DW'(MODE_BAD_B));
    bad_mode  = is_cmd && forbidden;
    launch    = is_cmd && !forbidden && wdata[7];
    go_wr     = launch && (ctrl == DW'(MODE_WR));
    go_rd     = launch && (ctrl == DW'(MODE_RD));
    size      = wdata[SZW-1:0];
  end
endmodule

// File: rtl/ixb_hidden_bank.sv
module ixb_hidden_bank
  import ixb_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned AW     = BANK_AW,
  parameter int unsigned SZW    = SIZE_W,
  parameter int unsigned NWORDS = 14,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic [AW-1:0]  base,
  input  logic [SZW-1:0] nwords,
  input  logic [DW-1:0]  src [NWORDS],
  input  logic [AW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] ent_view [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic [DW-1:0] ent_q;
    logic [DW-1:0] ent_d;
    logic          ent_en;

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      for (int k = 0; k < NWORDS; k++) begin
        if (load_en && (k < int'(nwords)) && ((base + AW'(k)) == AW'(j))) begin
          ent_d  = src[k];
          ent_en = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= (AW'(j) == AW'(BANK_RST_IDX)) ? DW'(BANK_RST_VAL) : '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign ent_view[j] = ent_q;
  end

  assign rd_data = ent_view[rd_idx];
endmodule

// File: rtl/ixb_host_regs.sv
module ixb_host_regs
  import ixb_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned HAW = HOST_AW,
  parameter int unsigned AW  = BANK_AW,
  parameter int unsigned SZW = SIZE_W,
  localparam int unsigned NREG   = 1 << HAW,
  localparam int unsigned NSTAGE = NREG - STG_DATA
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [7:0]     addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           bad_mode,
  input  logic           go_wr,
  input  logic           go_rd,
  input  logic [SZW-1:0] size,
  input  logic [DW-1:0]  bank_rd,
  output logic [DW-1:0]  ctrl,
  output logic [AW-1:0]  stage_idx,
  output logic [AW-1:0]  cur_idx,
  output logic [DW-1:0]  stage_data [NSTAGE]
);
  localparam int unsigned STAT = int'(OFF_STAT);
  localparam int unsigned PWR  = int'(OFF_PWR);
  localparam int unsigned CTRL = int'(OFF_CTRL);

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic          busy_q, busy_d;
  logic          err_q, err_d;
  logic [AW-1:0] cur_q, cur_d;

  logic in_window, wr_stat, wr_pwr, rd_stat, advance;

  always_comb begin
    in_window = (addr[7:HAW] == '0);
    wr_stat   = wr_en && (addr == OFF_STAT);
    wr_pwr    = wr_en && (addr == OFF_PWR);
    rd_stat   = rd_en && (addr == OFF_STAT);
    advance   = busy_q && (regs_q[STAT] < DW'(3));
  end

  // next state of the window, progress count, flags and latched index
  always_comb begin
    for (int k = 0; k < NREG; k++) regs_d[k] = regs_q[k];
    busy_d = busy_q;
    err_d  = err_q;
    cur_d  = cur_q;

    if (wr_en && in_window) begin
      if (wr_stat) regs_d[STAT] = regs_q[STAT] & ~DW'(3);
      else         regs_d[addr[HAW-1:0]] = wdata;
    end

    if (go_rd) begin
      for (int k = 0; k < NREG; k++) begin
        if ((k >= STG_IDX) && ((k - STG_IDX) < int'(size))) regs_d[k] = bank_rd;
      end
    end

    if (rd_stat && !wr_stat) begin
      if (advance) regs_d[STAT] = regs_q[STAT] + DW'(1);
      else         busy_d = 1'b0;
    end

    if (go_wr) cur_d = regs_q[STG_IDX][AW-1:0];

    if (go_wr || go_rd) begin
      busy_d = 1'b1;
      err_d  = 1'b0;
    end else if (bad_mode) begin
      err_d = 1'b1;
    end else if (wr_pwr) begin
      err_d = (wdata == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= (k == PWR) ? DW'(1) : '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cur_q  <= '0;
    end else begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= regs_d[k];
      busy_q <= busy_d;
      err_q  <= err_d;
      cur_q  <= cur_d;
    end
  end

  always_comb begin
    if (addr == OFF_STAT) rdata = {{(DW-2){1'b0}}, regs_q[STAT][1], err_q};
    else                  rdata = regs_q[addr[HAW-1:0]];
  end

  assign ctrl      = regs_q[CTRL];
  assign stage_idx = regs_q[STG_IDX][AW-1:0];
  assign cur_idx   = cur_q;
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    assign stage_data[s] = regs_q[STG_DATA + s];
  end

  // R3: a status write leaves the two low progress bits at zero
  a_r3_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (regs_q[STAT][1:0] == 2'b00));

  // R4: a command under a forbidden mode raises the error flag
  a_r4_bad_mode_err: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> err_q);

  // R8: a launched transfer is busy and error free afterwards
  a_r8_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr || go_rd) |=> (busy_q && !err_q));

  // R9: power write decides the error flag
  a_r9_power_err: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pwr |=> (err_q == ($past(wdata) == '0)));

  // R10: progress count saturates at 3
  a_r10_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[STAT] <= DW'(3));

  // R10: busy only appears after a launch
  a_r10_busy_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go_wr || go_rd));
endmodule

// File: rtl/ixreg_bridge.sv
module ixreg_bridge
  import ixb_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned HAW = HOST_AW,
  parameter int unsigned AW  = BANK_AW,
  parameter int unsigned SZW = SIZE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int unsigned NSTAGE = (1 << HAW) - STG_DATA;

  logic           bad_mode, go_wr, go_rd;
  logic [SZW-1:0] size, load_cnt;
  logic [DW-1:0]  ctrl, bank_rd;
  logic [AW-1:0]  stage_idx, cur_idx;
  logic [DW-1:0]  stage_data [NSTAGE];

  assign load_cnt = (size == '0) ? '0 : size - SZW'(1);

  ixb_cmd_decode #(.DW(DW), .SZW(SZW)) u_dec (
    .wr_en(host_wr), .wr_off(host_addr), .wdata(host_wdata), .ctrl(ctrl),
    .bad_mode(bad_mode), .go_wr(go_wr), .go_rd(go_rd), .size(size)
  );

  ixb_host_regs #(.DW(DW), .HAW(HAW), .AW(AW), .SZW(SZW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .rd_en(host_rd),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .bad_mode(bad_mode), .go_wr(go_wr), .go_rd(go_rd), .size(size),
    .bank_rd(bank_rd), .ctrl(ctrl), .stage_idx(stage_idx),
    .cur_idx(cur_idx), .stage_data(stage_data)
  );

  ixb_hidden_bank #(.DW(DW), .AW(AW), .SZW(SZW), .NWORDS(NSTAGE)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(go_wr), .base(stage_idx),
    .nwords(load_cnt), .src(stage_data), .rd_idx(cur_idx), .rd_data(bank_rd)
  );
endmodule

// File: tb/ixreg_bridge_tb_top.sv
module ixreg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  event        sample_ev;

  always #5 clk = ~clk;

  ixreg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // monitor: pops one expectation per sampled read
  always @(sample_ev) begin
    logic [15:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (host_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %02h actual %04h expected %04h", t, host_addr, host_rdata, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hw(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #2;
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> sample_ev;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic hr_nc(input logic [7:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic drain();
    hw(8'h06, 16'h0000);
    repeat (4) hr_nc(8'h06);
    hw(8'h06, 16'h0000);
  endtask

  task automatic latch_idx(input logic [7:0] idx);
    hw(8'h02, 16'h0043);
    hw(8'h10, {8'h00, idx});
    hw(8'h00, 16'h0081);
  endtask

  task automatic fetch(input logic [3:0] n);
    hw(8'h02, 16'h0042);
    hw(8'h00, {8'h00, 4'h8, n});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    hr(8'h00, 16'h0000, "R1 command word");
    hr(8'h02, 16'h0000, "R1 control word");
    hr(8'h0A, 16'h0001, "R1 power word");
    hr(8'h10, 16'h0000, "R1 staging word");
    hr(8'h06, 16'h0000, "R1 status");

    // R2 store, alias and ignored writes
    hw(8'h14, 16'hBEEF);
    hr(8'h14, 16'hBEEF, "R2 readback");
    hr(8'h34, 16'hBEEF, "R2 low-bit alias");
    hw(8'h24, 16'h1234);
    hr(8'h04, 16'h0000, "R2 out-of-window write ignored");
    hr(8'h14, 16'hBEEF, "R2 word kept");

    // R1 hidden reset value, R7 read copy count
    latch_idx(8'h7E);
    fetch(4'd2);
    hr(8'h10, 16'h001C, "R1 hidden 7E word0");
    hr(8'h11, 16'h001C, "R7 hidden 7E word1");
    hr(8'h12, 16'h0000, "R7 word past size untouched");

    // R10 progress sequence
    hr(8'h06, 16'h0000, "R10 status read 1");
    hr(8'h06, 16'h0000, "R10 status read 2");
    hr(8'h06, 16'h0002, "R10 status read 3");
    hr(8'h06, 16'h0002, "R10 status read 4");
    hr(8'h06, 16'h0002, "R10 status read 5");
    // R3 status write clears and is not stored
    hw(8'h06, 16'hFFFF);
    hr(8'h06, 16'h0000, "R3 status after clear");
    hr(8'h06, 16'h0000, "R10 idle status stays");

    // R6 wrap and word count
    hw(8'h02, 16'h0043);
    hw(8'h10, 16'h00FE);
    hw(8'h12, 16'hA001);
    hw(8'h13, 16'hA002);
    hw(8'h14, 16'hA003);
    hw(8'h00, 16'h0084);
    fetch(4'd1);
    hr(8'h10, 16'hA001, "R6 hidden FE");
    hr(8'h11, 16'h001C, "R7 size one leaves word1");
    latch_idx(8'hFF); fetch(4'd1);
    hr(8'h10, 16'hA002, "R6 hidden FF");
    latch_idx(8'h00); fetch(4'd1);
    hr(8'h10, 16'hA003, "R6 hidden 00 after wrap");
    latch_idx(8'h01); fetch(4'd1);
    hr(8'h10, 16'h0000, "R6 hidden 01 not written");
    latch_idx(8'hFD); fetch(4'd1);
    hr(8'h10, 16'h0000, "R6 hidden FD not written");

    // R4 forbidden modes
    drain();
    hw(8'h02, 16'h004F);
    hw(8'h10, 16'h5555);
    hw(8'h00, 16'h0082);
    hr(8'h06, 16'h0001, "R4 error after 4F");
    hr(8'h06, 16'h0001, "R4 no busy after 4F");
    hr(8'h10, 16'h5555, "R4 staging untouched");
    hw(8'h0A, 16'h0001);
    hr(8'h06, 16'h0000, "R9 power up clears error");
    hw(8'h02, 16'h0041);
    hw(8'h00, 16'h0081);
    hr(8'h06, 16'h0001, "R4 error after 41");

    // R8 launch clears error
    fetch(4'd1);
    hr(8'h06, 16'h0000, "R8 error cleared by launch");
    hr(8'h10, 16'h0000, "R7 copy of hidden FD");

    // R9 power
    hw(8'h0A, 16'h0000);
    hr(8'h06, 16'h0001, "R9 power down error");
    hw(8'h0A, 16'h0005);
    hr(8'h0A, 16'h0005, "R9 power value stored");
    hr(8'h06, 16'h0002, "R9 error cleared, R10 ready");

    // R5 no launch without start bit or with unknown mode
    drain();
    hw(8'h02, 16'h0042);
    hw(8'h10, 16'h7777);
    hw(8'h00, 16'h0002);
    hr(8'h10, 16'h7777, "R5 start bit clear moves nothing");
    hr(8'h06, 16'h0000, "R5 no busy read 1");
    hr(8'h06, 16'h0000, "R5 no busy read 2");
    hw(8'h02, 16'h0050);
    hw(8'h00, 16'h0083);
    hr(8'h10, 16'h7777, "R5 unknown mode moves nothing");
    hr(8'h06, 16'h0000, "R5 unknown mode no busy");
    hr(8'h00, 16'h0083, "R2 command word stored");

    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule